// File: doc/BRIEF.md
# EEPROM Program/Erase Sequencing Controller

This block holds a small byte-addressable non-volatile array, plus one hidden configuration byte, behind a simple byte bus. Software cannot write the array directly. It first opens a latch window in the program control register. It then writes one address and data byte, which the block latches. Next it switches the programming voltage on and leaves it on for a minimum number of cycles. When a control write switches the voltage off, the block commits the operation selected by the mode bits. That operation is one of: program a byte (bits can only be cleared), erase a byte, erase a 16-byte row, or erase the whole array.

A configuration byte is stored one location past the end of the array. It is written through its own register address and is never visible in the array window. The live configuration register loads from this stored byte on reset. Its enable bit decides whether the array window answers bus accesses until the next reset. Protocol mistakes do not stop the block. Each one raises a one-cycle error pulse that carries a cause code.

Top module: `eeprom_pe_ctrl`

## Requirements
- R1: The program control register has five bits: bit4 byte mode, bit3 row mode, bit2 erase, bit1 latch enable, bit0 voltage enable. Bits 7:5 read as zero. A write with bit1=1 stores bits 4:0. Voltage enable is never set while latch enable is clear.
- R2: A control write that sets bits 1 and 0 together, while both are clear, is rejected. The register keeps its value and error code 1 is reported.
- R3: A control write with bit1=0 stores 0x00 and discards any latched address/data pair.
- R4: A control write that raises voltage enable while no address/data pair is latched reports error code 2. The write is still stored.
- R5: While latch enable is set, the first write to the array or configuration address latches address and byte and leaves the array unchanged. A further write before the commit reports code 3 and is ignored. A data write with latch enable clear reports code 4.
- R6: The commit happens on the control write that clears voltage enable while a pair is latched. The block counts the write-to-write distance N in cycles with a 16-bit saturating counter. If N is below MIN_DWELL (10000), it reports code 5 and still commits.
- R7: With erase=0, the commit replaces the target byte with the AND of its old value and the latched byte.
- R8: With erase=1, if byte mode=1 or the target is the configuration byte, only the target byte becomes 0xFF.
- R9: With erase=1, byte mode=0 and row mode=1, the 16 array bytes that share the target's address bits above bit 3 become 0xFF. No other byte changes.
- R10: With erase=1 and both byte and row modes clear, every array byte and the stored configuration byte become 0xFF.
- R11: An array-window read while latch enable is set returns 0x00 and reports code 6.
- R12: The configuration address reads the live configuration register. That register loads from the stored configuration byte on reset and does not change between resets. Programming the stored byte therefore takes effect only after the next reset.
- R13: The array window answers only when bit0 of the live configuration is 1. Otherwise array reads return 0x00 and array writes are ignored without error. Power-up content of the array and the stored configuration byte is 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_en | input | 1 | Access strobe, one access per asserted cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_sel | input | 2 | Target: 0 array window, 1 control register, 2 configuration register, 3 none |
| bus_addr | input | 9 | Array byte address (used with bus_sel=0) |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid in the access cycle |
| err_valid | output | 1 | One-cycle error pulse in the cycle after the offending access |
| err_code | output | 3 | Cause: 1 reject, 2 no latch, 3 double write, 4 no latch enable, 5 short dwell, 6 read while latched |

## Verification
Several properties are checked on every cycle:
- Voltage enable is only ever set together with latch enable, and a latched pair exists only while latch enable is set.
- A rejected control write leaves the register as it was.
- A program commit never sets a bit.
- The dwell counter stays at its maximum once it saturates.
- The live configuration and the window gate are frozen between resets.

Other behaviours depend on whole sequences, and only the bench scenarios show them. These are the exact extent of a row or bulk erase, a dwell of 9999 against 10000 cycles, and the special erase rule for the configuration byte. They also include the configuration change becoming visible only across a reset, and the window closing after that reset.

// File: rtl/eeprom_pe_ctrl.sv
module eeprom_pe_ctrl #(
  parameter int ARRAY_BYTES = 512,
  parameter int ROW_BYTES   = 16,
  parameter int CNT_W       = 16,
  parameter int MIN_DWELL   = 10000,
  parameter int EN_BIT      = 0
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             bus_en,
  input  logic                             bus_we,
  input  logic [1:0]                       bus_sel,
  input  logic [$clog2(ARRAY_BYTES)-1:0]   bus_addr,
  input  logic [7:0]                       bus_wdata,
  output logic [7:0]                       bus_rdata,
  output logic                             err_valid,
  output logic [2:0]                       err_code
);
  localparam int IDX_W  = $clog2(ARRAY_BYTES + 1);
  localparam int ROW_SH = $clog2(ROW_BYTES);
  localparam logic [IDX_W-1:0] CFG_IDX = IDX_W'(ARRAY_BYTES);
  localparam logic [CNT_W-1:0] DWELL   = CNT_W'(MIN_DWELL);
  localparam logic [1:0] SEL_ARR = 2'd0, SEL_CTL = 2'd1, SEL_CFG = 2'd2;

  logic [7:0]       mem [0:ARRAY_BYTES] = '{default: 8'hFF};
  logic [4:0]       ctrl;
  logic [7:0]       cfg_live;
  logic             win_on;
  logic             lat_v;
  logic [IDX_W-1:0] lat_idx;
  logic [7:0]       lat_byte;
  logic [CNT_W-1:0] dwell_cnt;
  logic [2:0]       code;

  logic [IDX_W-1:0] addr_idx;
  logic acc_arr, acc_ctl, acc_cfg, data_wr, ctl_wr, arr_rd;
  logic reject, ctl_take, pgm_rise, commit;
  logic [4:0] nv;

  assign addr_idx = IDX_W'(bus_addr);
  assign acc_arr  = rst_n && bus_en && bus_sel == SEL_ARR && win_on && addr_idx < CFG_IDX;
  assign acc_ctl  = rst_n && bus_en && bus_sel == SEL_CTL;
  assign acc_cfg  = rst_n && bus_en && bus_sel == SEL_CFG;
  assign data_wr  = bus_we && (acc_arr || acc_cfg);
  assign ctl_wr   = bus_we && acc_ctl;
  assign arr_rd   = !bus_we && acc_arr;

  assign nv       = bus_wdata[1] ? bus_wdata[4:0] : 5'd0;
  assign reject   = ctl_wr && bus_wdata[1] && bus_wdata[0] && !ctrl[1] && !ctrl[0];
  assign ctl_take = ctl_wr && !reject;
  assign pgm_rise = ctl_take && nv[0] && !ctrl[0];
  assign commit   = ctl_take && ctrl[0] && !nv[0] && lat_v;

  always_comb begin
    if (reject)                      code = 3'd1;
    else if (pgm_rise && !lat_v)     code = 3'd2;
    else if (commit && dwell_cnt < DWELL) code = 3'd5;
    else if (data_wr && !ctrl[1])    code = 3'd4;
    else if (data_wr && lat_v)       code = 3'd3;
    else if (arr_rd && ctrl[1])      code = 3'd6;
    else                             code = 3'd0;
  end

  always_comb begin
    bus_rdata = 8'h00;
    if (acc_ctl)                     bus_rdata = {3'b000, ctrl};
    else if (acc_cfg)                bus_rdata = cfg_live;
    else if (acc_arr && !ctrl[1])    bus_rdata = mem[addr_idx];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl      <= '0;
      lat_v     <= 1'b0;
      lat_idx   <= '0;
      lat_byte  <= '0;
      dwell_cnt <= '0;
      err_valid <= 1'b0;
      err_code  <= '0;
      cfg_live  <= mem[CFG_IDX];
      win_on    <= mem[CFG_IDX][EN_BIT];
    end else begin
      err_valid <= code != 3'd0;
      err_code  <= code;
      if (ctl_take) ctrl <= nv;
      if (pgm_rise) dwell_cnt <= CNT_W'(1);
      else if (ctrl[0] && dwell_cnt != '1) dwell_cnt <= dwell_cnt + 1'b1;
      if (commit || (ctl_take && !nv[1])) begin
        lat_v <= 1'b0;
      end else if (data_wr && ctrl[1] && !lat_v) begin
        lat_v    <= 1'b1;
        lat_idx  <= acc_cfg ? CFG_IDX : addr_idx;
        lat_byte <= bus_wdata;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (commit) begin
      for (int i = 0; i <= ARRAY_BYTES; i++) begin
        if (!ctrl[2]) begin
          if (IDX_W'(i) == lat_idx) mem[i] <= mem[i] & lat_byte;
        end else if (ctrl[4] || lat_idx == CFG_IDX) begin
          if (IDX_W'(i) == lat_idx) mem[i] <= 8'hFF;
        end else if (ctrl[3]) begin
          if (i < ARRAY_BYTES && (IDX_W'(i) >> ROW_SH) == (lat_idx >> ROW_SH))
            mem[i] <= 8'hFF;
        end else begin
          mem[i] <= 8'hFF;
        end
      end
    end
  end

  AST_PGM_NEEDS_LATCH_EN: assert property (@(posedge clk) disable iff (!rst_n) ctrl[0] |-> ctrl[1]); // R1
  AST_REJECT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n) reject |=> ctrl == $past(ctrl)); // R2
  AST_PAIR_NEEDS_LATCH_EN: assert property (@(posedge clk) disable iff (!rst_n) lat_v |-> ctrl[1]); // R5
  AST_DWELL_SATURATES: assert property (@(posedge clk) disable iff (!rst_n) (dwell_cnt == '1 && !pgm_rise) |=> dwell_cnt == '1); // R6
  AST_PROGRAM_ONLY_CLEARS: assert property (@(posedge clk) disable iff (!rst_n) (commit && !ctrl[2]) |=> (mem[lat_idx] & ~$past(mem[lat_idx])) == 8'h00); // R7
  AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n) 1'b1 |=> $stable(cfg_live) && $stable(win_on)); // R12
endmodule

// File: tb/test_eeprom_pe_ctrl.sv
`timescale 1ns/1ps
module test_eeprom_pe_ctrl;
  logic clk = 1'b0, rst_n = 1'b0, bus_en = 1'b0, bus_we = 1'b0;
  logic [1:0] bus_sel = 2'd3;
  logic [8:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0, bus_rdata;
  logic err_valid;
  logic [2:0] err_code;
  int n_chk = 0, n_fail = 0;

  localparam logic [1:0] ARR = 2'd0, CTL = 2'd1, CFG = 2'd2;

  eeprom_pe_ctrl i_eeprom_pe_ctrl (.clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
    .bus_sel(bus_sel), .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .err_valid(err_valid), .err_code(err_code));

  always #2.5 clk = ~clk;

  function automatic logic [7:0] ec(input int c);
    return (c == 0) ? 8'h00 : {4'h0, 1'b1, 3'(c)};
  endfunction

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic op(input logic [1:0] sel, input logic we, input logic [8:0] a,
                    input logic [7:0] d, output logic [7:0] rd, output logic [7:0] er);
    @(negedge clk);
    bus_en = 1'b1; bus_we = we; bus_sel = sel; bus_addr = a; bus_wdata = d;
    #1 rd = bus_rdata;
    @(posedge clk);
    #1 er = {4'h0, err_valid, err_code};
    bus_en = 1'b0; bus_we = 1'b0;
  endtask

  task automatic wr(input logic [1:0] sel, input logic [8:0] a, input logic [7:0] d,
                    input int code, input string req);
    logic [7:0] rd, er;
    op(sel, 1'b1, a, d, rd, er);
    chk(req, er, ec(code));
  endtask

  task automatic rdc(input logic [1:0] sel, input logic [8:0] a, input logic [7:0] exp,
                     input int code, input string req);
    logic [7:0] rd, er;
    op(sel, 1'b0, a, 8'h00, rd, er);
    chk(req, rd, exp);
    chk(req, er, ec(code));
  endtask

  task automatic do_reset;
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
  endtask

  task automatic commit_seq(input logic [1:0] sel, input logic [8:0] a, input logic [7:0] d,
                            input logic [7:0] mode, input int n, input int code, input string req);
    wr(CTL, 0, mode | 8'h02, 0, req);
    wr(sel, a, d, 0, req);
    wr(CTL, 0, mode | 8'h03, 0, req);
    repeat (n - 1) @(posedge clk);
    wr(CTL, 0, 8'h00, code, req);
  endtask

  task automatic t_reset_state;
    rdc(CTL, 0, 8'h00, 0, "R1 ctrl after reset");
    rdc(CFG, 0, 8'hFF, 0, "R12 cfg after reset");
    rdc(ARR, 0, 8'hFF, 0, "R13 blank array");
  endtask

  task automatic t_ctrl_bits;
    wr(CTL, 0, 8'hFE, 0, "R1");
    rdc(CTL, 0, 8'h1E, 0, "R1 upper bits zero");
    wr(CTL, 0, 8'h00, 0, "R1");
    wr(CTL, 0, 8'h03, 1, "R2 both set rejected");
    rdc(CTL, 0, 8'h00, 0, "R2 ctrl unchanged");
    wr(CTL, 0, 8'h06, 0, "R3");
    wr(CTL, 0, 8'h14, 0, "R3");
    rdc(CTL, 0, 8'h00, 0, "R3 latch-clear zeroes register");
    wr(CTL, 0, 8'h02, 0, "R3");
    wr(ARR, 7, 8'h00, 0, "R3");
    wr(CTL, 0, 8'h00, 0, "R3");
    wr(CTL, 0, 8'h02, 0, "R3");
    wr(ARR, 8, 8'h00, 0, "R3 pair discarded");
    wr(CTL, 0, 8'h00, 0, "R3");
  endtask

  task automatic t_latch_rules;
    wr(CTL, 0, 8'h02, 0, "R4");
    wr(CTL, 0, 8'h03, 2, "R4 voltage without pair");
    rdc(CTL, 0, 8'h03, 0, "R4 write stored");
    wr(CTL, 0, 8'h00, 0, "R4 no commit");
    rdc(ARR, 0, 8'hFF, 0, "R4 array untouched");
    wr(CTL, 0, 8'h02, 0, "R5");
    wr(ARR, 5, 8'h0F, 0, "R5 first write latches");
    wr(ARR, 6, 8'h00, 3, "R5 second write");
    wr(CTL, 0, 8'h00, 0, "R5");
    rdc(ARR, 5, 8'hFF, 0, "R5 array unchanged");
    rdc(ARR, 6, 8'hFF, 0, "R5 array unchanged");
    wr(ARR, 5, 8'h00, 4, "R5 write without latch enable");
    wr(CTL, 0, 8'h02, 0, "R11");
    rdc(ARR, 5, 8'h00, 6, "R11 read while latched");
    wr(CTL, 0, 8'h00, 0, "R11");
  endtask

  task automatic t_program;
    commit_seq(ARR, 5, 8'h5A, 8'h00, 10000, 0, "R6 dwell 10000");
    rdc(ARR, 5, 8'h5A, 0, "R7 program");
    commit_seq(ARR, 5, 8'h0F, 8'h00, 9999, 5, "R6 dwell 9999");
    rdc(ARR, 5, 8'h0A, 0, "R7 AND only clears");
  endtask

  task automatic t_erase;
    commit_seq(ARR, 6, 8'h00, 8'h00, 20, 5, "R6 short");
    commit_seq(ARR, 5, 8'h00, 8'h14, 10000, 0, "R8 byte erase");
    rdc(ARR, 5, 8'hFF, 0, "R8 target erased");
    rdc(ARR, 6, 8'h00, 0, "R8 neighbour kept");
    commit_seq(ARR, 9'h20, 8'h11, 8'h00, 20, 5, "R9 setup");
    commit_seq(ARR, 9'h2F, 8'h00, 8'h00, 20, 5, "R9 setup");
    commit_seq(ARR, 9'h30, 8'h00, 8'h00, 20, 5, "R9 setup");
    rdc(ARR, 9'h20, 8'h11, 0, "R9 setup");
    commit_seq(ARR, 9'h25, 8'h00, 8'h0C, 20, 5, "R9 row erase");
    rdc(ARR, 9'h20, 8'hFF, 0, "R9 row start");
    rdc(ARR, 9'h2F, 8'hFF, 0, "R9 row end");
    rdc(ARR, 9'h30, 8'h00, 0, "R9 next row kept");
    rdc(ARR, 6, 8'h00, 0, "R9 other row kept");
  endtask

  task automatic t_config;
    commit_seq(CFG, 0, 8'hFE, 8'h00, 10000, 0, "R12 program cfg");
    rdc(CFG, 0, 8'hFF, 0, "R12 live unchanged before reset");
    do_reset();
    rdc(CFG, 0, 8'hFE, 0, "R12 live after reset");
    rdc(ARR, 9'h30, 8'h00, 0, "R13 window closed");
    rdc(ARR, 9'h20, 8'h00, 0, "R13 window closed");
    wr(CTL, 0, 8'h02, 0, "R13");
    rdc(ARR, 9'h20, 8'h00, 0, "R13 no read error when closed");
    wr(ARR, 9'h20, 8'h00, 0, "R13 write ignored");
    wr(CTL, 0, 8'h00, 0, "R13");
    commit_seq(CFG, 0, 8'h00, 8'h0C, 20, 5, "R8 cfg erase in row mode");
    do_reset();
    rdc(CFG, 0, 8'hFF, 0, "R8 cfg erased");
    rdc(ARR, 9'h30, 8'h00, 0, "R8 row not erased");
    rdc(ARR, 9'h20, 8'hFF, 0, "R13 window open");
  endtask

  task automatic t_bulk;
    commit_seq(CFG, 0, 8'hFE, 8'h00, 20, 5, "R10 setup");
    commit_seq(ARR, 0, 8'h00, 8'h04, 20, 5, "R10 bulk erase");
    rdc(ARR, 9'h30, 8'hFF, 0, "R10 array erased");
    rdc(ARR, 6, 8'hFF, 0, "R10 array erased");
    do_reset();
    rdc(CFG, 0, 8'hFF, 0, "R10 cfg erased");
  endtask

  task automatic summary;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    do_reset();
    t_reset_state();
    t_ctrl_bits();
    t_latch_rules();
    t_program();
    t_erase();
    t_config();
    t_bulk();
    summary();
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end
endmodule